// File: doc/BRIEF.md
# Serial Configuration Write Port

This block receives register writes over a three-signal serial link: a serial clock, a load strobe and a serial data line. All three are brought into the system clock domain through two-flop synchronizers. Rising edges of the serial clock and of the load strobe are detected in that domain. Each transfer starts with an 8-bit register address. Data words follow, and the address alone decides how many words are expected and how wide each one is.

Ordinary control addresses take one 24-bit word. A small range of bank addresses takes several 32-bit words, one word for each bank entry. Nothing reaches the register bank while bits are arriving. The received words are written only when the load strobe rises after the final bit of the last word. The commit drives the parallel write port with one pulse for each word, on consecutive cycles, and the sub-index counts up from zero.

The serial master must hold each serial level for several system clock cycles. It must also leave a short gap after the strobe before it starts the next transfer.

Top module: `scp_write_port`

## Requirements
- R1: While reset is active, and after it is released, `wr_en_o` is low. A reset in the middle of a transfer discards the partial transfer, so the next complete transfer commits only its own address and data.
- R2: The address is the first 8 serial bits, least significant bit first. Each bit is the level of the data line sampled at a rising edge of the serial clock.
- R3: An address outside the bank range 0x14 to 0x16 takes exactly one 24-bit data word, least significant bit first. It is written as `wr_data_o` bits 23:0, with bits 31:24 zero and sub-index 0.
- R4: An address from 0x14 to 0x16 inclusive takes BANK_WORDS (default 4) data words of 32 bits each, least significant bit first. The first word received carries sub-index 0.
- R5: A rising edge of the load strobe that arrives before the last data bit has been shifted in produces no write, and the transfer in progress carries on.
- R6: A load strobe rise after the last data bit produces exactly one `wr_en_o` pulse for each word, on consecutive cycles. `wr_addr_o` holds the received address and `wr_idx_o` counts up by one from 0.
- R7: Serial clock edges that arrive after the last data bit and before the strobe are ignored, and the committed data is unchanged by them.
- R8: After a commit the port returns to waiting for an address, and a following transfer commits correctly.
- R9: A load strobe rise when no transfer is in progress produces no write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low reset, clears all state |
| scp_sclk_i | input | 1 | Serial clock, asynchronous to clk_i |
| scp_load_i | input | 1 | Serial load strobe, asynchronous |
| scp_sdi_i | input | 1 | Serial data in |
| wr_en_o | output | 1 | Register bank write enable, one pulse per word |
| wr_addr_o | output | 8 | Register address of the write |
| wr_idx_o | output | 2 | Word sub-index within the transfer |
| wr_data_o | output | 32 | Word data, control words zero-extended |

## Verification
The assertions check four things on every cycle. A strobe seen while the address or data is still arriving never moves the port into commit. Extra clock edges in the full state leave the captured words untouched. The bit counter stays inside the field width. A commit burst starts at sub-index 0 and steps by one under a constant address. Only the bench scenarios can show that the serial bit order, the choice of word count at the bank range edges, the zero extension of control words, the discard of a partial transfer by reset, and a correct transfer following directly after another give the expected values at the write port.

// File: rtl/scp_pkg.sv
package scp_pkg;

    typedef enum logic [1:0] {
        SCP_ADDR   = 2'd0,
        SCP_DATA   = 2'd1,
        SCP_FULL   = 2'd2,
        SCP_COMMIT = 2'd3
    } scp_state_e;

endpackage

// File: rtl/scp_sync.sv
module scp_sync #(
    parameter int             W         = 3,
    parameter logic [W-1:0]   EDGE_MASK = '0
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] out_o
);

    logic [W-1:0] meta_d, meta_q;
    logic [W-1:0] stab_d, stab_q;

    always_comb begin
        meta_d = async_i;
        stab_d = meta_q;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            meta_q <= '0;
            stab_q <= '0;
        end else begin
            meta_q <= meta_d;
            stab_q <= stab_d;
        end
    end

    for (genvar i = 0; i < W; i++) begin : g_bit
        if (EDGE_MASK[i]) begin : g_edge
            logic prev_d, prev_q;
            always_comb prev_d = stab_q[i];
            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni) prev_q <= 1'b0;
                else         prev_q <= prev_d;
            end
            assign out_o[i] = stab_q[i] & ~prev_q;
        end else begin : g_level
            assign out_o[i] = stab_q[i];
        end
    end

endmodule

// File: rtl/scp_shifter.sv
module scp_shifter
    import scp_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int CTRL_W     = 24,
    parameter int BANK_W     = 32,
    parameter int BANK_WORDS = 4,
    parameter int BANK_LO    = 20,
    parameter int BANK_HI    = 22,
    localparam int IDX_W     = (BANK_WORDS > 1) ? $clog2(BANK_WORDS) : 1,
    localparam int BIT_W     = $clog2((BANK_W > ADDR_W) ? BANK_W : ADDR_W),
    localparam int ABIT_W    = $clog2(ADDR_W)
) (
    input  logic                                  clk_i,
    input  logic                                  rst_ni,
    input  logic                                  bit_stb_i,
    input  logic                                  bit_i,
    input  logic                                  load_stb_i,
    input  logic                                  done_i,
    output logic                                  commit_o,
    output logic [ADDR_W-1:0]                     addr_o,
    output logic [IDX_W-1:0]                      last_o,
    output logic [BANK_WORDS-1:0][BANK_W-1:0]     words_o
);

    typedef struct packed {
        scp_state_e                           st;
        logic [ADDR_W-1:0]                    addr;
        logic [BIT_W-1:0]                     bitcnt;
        logic [BIT_W-1:0]                     wlast;
        logic [IDX_W-1:0]                     wordcnt;
        logic [IDX_W-1:0]                     last;
        logic [BANK_WORDS-1:0][BANK_W-1:0]    words;
    } shf_t;

    shf_t shf_d, shf_q;

    logic [ADDR_W-1:0] addr_full;
    logic              is_bank;

    // The last address bit arrives with the final strobe, so decode the complete value
    always_comb begin
        addr_full = {bit_i, shf_q.addr[ADDR_W-2:0]};
        is_bank   = (addr_full >= ADDR_W'(BANK_LO)) && (addr_full <= ADDR_W'(BANK_HI));
    end

    always_comb begin
        shf_d = shf_q;
        unique case (shf_q.st)
            SCP_ADDR: begin
                if (bit_stb_i) begin
                    shf_d.addr[shf_q.bitcnt[ABIT_W-1:0]] = bit_i;
                    if (shf_q.bitcnt == BIT_W'(ADDR_W-1)) begin
                        shf_d.bitcnt  = '0;
                        shf_d.wordcnt = '0;
                        shf_d.words   = '0;
                        shf_d.st      = SCP_DATA;
                        if (is_bank) begin
                            shf_d.last  = IDX_W'(BANK_WORDS-1);
                            shf_d.wlast = BIT_W'(BANK_W-1);
                        end else begin
                            shf_d.last  = '0;
                            shf_d.wlast = BIT_W'(CTRL_W-1);
                        end
                    end else begin
                        shf_d.bitcnt = shf_q.bitcnt + 1'b1;
                    end
                end
            end
            SCP_DATA: begin
                if (bit_stb_i) begin
                    shf_d.words[shf_q.wordcnt][shf_q.bitcnt] = bit_i;
                    if (shf_q.bitcnt == shf_q.wlast) begin
                        shf_d.bitcnt = '0;
                        if (shf_q.wordcnt == shf_q.last) begin
                            shf_d.st = SCP_FULL;
                        end else begin
                            shf_d.wordcnt = shf_q.wordcnt + 1'b1;
                        end
                    end else begin
                        shf_d.bitcnt = shf_q.bitcnt + 1'b1;
                    end
                end
            end
            SCP_FULL: begin
                if (load_stb_i) shf_d.st = SCP_COMMIT;
            end
            SCP_COMMIT: begin
                if (done_i) begin
                    shf_d.st      = SCP_ADDR;
                    shf_d.bitcnt  = '0;
                    shf_d.wordcnt = '0;
                end
            end
            default: shf_d.st = SCP_ADDR;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) shf_q <= '0;
        else         shf_q <= shf_d;
    end

    assign commit_o = (shf_q.st == SCP_COMMIT);
    assign addr_o   = shf_q.addr;
    assign last_o   = shf_q.last;
    assign words_o  = shf_q.words;

    // R5
    early_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (load_stb_i && (shf_q.st == SCP_ADDR || shf_q.st == SCP_DATA)) |=> (shf_q.st != SCP_COMMIT));

    // R7
    full_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (shf_q.st == SCP_FULL && !load_stb_i) |=> (shf_q.st == SCP_FULL) && $stable(shf_q.words));

    // R4
    bit_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (shf_q.st == SCP_DATA) |-> (shf_q.bitcnt <= shf_q.wlast));

endmodule

// File: rtl/scp_commit.sv
module scp_commit #(
    parameter int ADDR_W     = 8,
    parameter int BANK_W     = 32,
    parameter int BANK_WORDS = 4,
    localparam int IDX_W     = (BANK_WORDS > 1) ? $clog2(BANK_WORDS) : 1
) (
    input  logic                               clk_i,
    input  logic                               rst_ni,
    input  logic                               req_i,
    input  logic [ADDR_W-1:0]                  addr_i,
    input  logic [IDX_W-1:0]                   last_i,
    input  logic [BANK_WORDS-1:0][BANK_W-1:0]  words_i,
    output logic                               done_o,
    output logic                               wr_en_o,
    output logic [ADDR_W-1:0]                  wr_addr_o,
    output logic [IDX_W-1:0]                   wr_idx_o,
    output logic [BANK_W-1:0]                  wr_data_o
);

    typedef struct packed {
        logic [IDX_W-1:0]  idx;
        logic              done;
        logic              en;
        logic [ADDR_W-1:0] addr;
        logic [IDX_W-1:0]  wr_idx;
        logic [BANK_W-1:0] data;
    } cmt_t;

    cmt_t cmt_d, cmt_q;

    always_comb begin
        cmt_d      = cmt_q;
        cmt_d.en   = 1'b0;
        cmt_d.done = 1'b0;
        if (req_i && !cmt_q.done) begin
            cmt_d.en     = 1'b1;
            cmt_d.addr   = addr_i;
            cmt_d.wr_idx = cmt_q.idx;
            cmt_d.data   = words_i[cmt_q.idx];
            if (cmt_q.idx == last_i) begin
                cmt_d.idx  = '0;
                cmt_d.done = 1'b1;
            end else begin
                cmt_d.idx = cmt_q.idx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cmt_q <= '0;
        else         cmt_q <= cmt_d;
    end

    assign done_o    = cmt_q.done;
    assign wr_en_o   = cmt_q.en;
    assign wr_addr_o = cmt_q.addr;
    assign wr_idx_o  = cmt_q.wr_idx;
    assign wr_data_o = cmt_q.data;

    // R6
    idx_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_o && $past(wr_en_o)) |-> (wr_idx_o == IDX_W'($past(wr_idx_o) + 1'b1)) && $stable(wr_addr_o));

    // R6
    first_idx_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(wr_en_o) |-> (wr_idx_o == '0));

    // R6
    idx_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_en_o |-> (wr_idx_o <= last_i));

endmodule

// File: rtl/scp_write_port.sv
module scp_write_port #(
    parameter int ADDR_W     = 8,
    parameter int CTRL_W     = 24,
    parameter int BANK_W     = 32,
    parameter int BANK_WORDS = 4,
    parameter int BANK_LO    = 20,
    parameter int BANK_HI    = 22,
    localparam int IDX_W     = (BANK_WORDS > 1) ? $clog2(BANK_WORDS) : 1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              scp_sclk_i,
    input  logic              scp_load_i,
    input  logic              scp_sdi_i,
    output logic              wr_en_o,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic [IDX_W-1:0]  wr_idx_o,
    output logic [BANK_W-1:0] wr_data_o
);

    // bit 0: serial clock rise, bit 1: load rise, bit 2: data level
    logic [2:0]                          sync_out;
    logic                                commit_req;
    logic                                commit_done;
    logic [ADDR_W-1:0]                   xfer_addr;
    logic [IDX_W-1:0]                    xfer_last;
    logic [BANK_WORDS-1:0][BANK_W-1:0]   xfer_words;

    scp_sync #(
        .W         (3),
        .EDGE_MASK (3'b011)
    ) u_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i ({scp_sdi_i, scp_load_i, scp_sclk_i}),
        .out_o   (sync_out)
    );

    scp_shifter #(
        .ADDR_W     (ADDR_W),
        .CTRL_W     (CTRL_W),
        .BANK_W     (BANK_W),
        .BANK_WORDS (BANK_WORDS),
        .BANK_LO    (BANK_LO),
        .BANK_HI    (BANK_HI)
    ) u_shifter (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .bit_stb_i  (sync_out[0]),
        .bit_i      (sync_out[2]),
        .load_stb_i (sync_out[1]),
        .done_i     (commit_done),
        .commit_o   (commit_req),
        .addr_o     (xfer_addr),
        .last_o     (xfer_last),
        .words_o    (xfer_words)
    );

    scp_commit #(
        .ADDR_W     (ADDR_W),
        .BANK_W     (BANK_W),
        .BANK_WORDS (BANK_WORDS)
    ) u_commit (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .req_i     (commit_req),
        .addr_i    (xfer_addr),
        .last_i    (xfer_last),
        .words_i   (xfer_words),
        .done_o    (commit_done),
        .wr_en_o   (wr_en_o),
        .wr_addr_o (wr_addr_o),
        .wr_idx_o  (wr_idx_o),
        .wr_data_o (wr_data_o)
    );

endmodule

// File: tb/scp_write_port_tb.sv
`timescale 1ns/1ps
module scp_write_port_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sclk = 1'b0;
    logic        sload = 1'b0;
    logic        sdi = 1'b0;
    logic        wr_en;
    logic [7:0]  wr_addr;
    logic [1:0]  wr_idx;
    logic [31:0] wr_data;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    int          cyc = 0;
    int          cap_n = 0;
    logic [7:0]  cap_addr [32];
    logic [1:0]  cap_idx  [32];
    logic [31:0] cap_data [32];
    int          cap_cyc  [32];

    always #5 clk = ~clk;

    scp_write_port dut_i (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .scp_sclk_i (sclk),
        .scp_load_i (sload),
        .scp_sdi_i  (sdi),
        .wr_en_o    (wr_en),
        .wr_addr_o  (wr_addr),
        .wr_idx_o   (wr_idx),
        .wr_data_o  (wr_data)
    );

    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (wr_en && cap_n < 32) begin
            cap_addr[cap_n] = wr_addr;
            cap_idx[cap_n]  = wr_idx;
            cap_data[cap_n] = wr_data;
            cap_cyc[cap_n]  = cyc;
            cap_n = cap_n + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send_bits(input logic [31:0] v, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) sdi = v[i];
            repeat (4) @(negedge clk);
            sclk = 1'b1;
            repeat (4) @(negedge clk);
            sclk = 1'b0;
        end
    endtask

    task automatic pulse_load();
        repeat (4) @(negedge clk);
        sload = 1'b1;
        repeat (4) @(negedge clk);
        sload = 1'b0;
        repeat (20) @(negedge clk);
    endtask

    task automatic check_ctrl_write(input int base, input logic [7:0] a, input logic [23:0] d, input string req);
        chk(cap_n == base + 1, req, cap_n - base, 1);
        if (cap_n > base) begin
            chk(cap_addr[base] == a, req, cap_addr[base], a);
            chk(cap_idx[base] == 2'd0, req, cap_idx[base], 0);
            chk(cap_data[base] == {8'h00, d}, req, cap_data[base], {8'h00, d});
        end
    endtask

    task automatic t_reset();
        chk(wr_en == 1'b0, "R1 during reset", wr_en, 0);
        @(negedge clk) rst_n = 1'b1;
        repeat (10) @(negedge clk);
        chk(wr_en == 1'b0 && cap_n == 0, "R1 after reset", cap_n, 0);
    endtask

    task automatic t_ctrl_word();
        int base = cap_n;
        send_bits(32'h05, 8);
        send_bits(32'hA5C3F1, 24);
        pulse_load();
        check_ctrl_write(base, 8'h05, 24'hA5C3F1, "R2 R3 control word");
    endtask

    task automatic t_bank_words();
        int base = cap_n;
        logic [31:0] w [4];
        w[0] = 32'hDEADBEEF; w[1] = 32'h01234567; w[2] = 32'h89ABCDEF; w[3] = 32'hF00DCAFE;
        send_bits(32'h15, 8);
        for (int k = 0; k < 4; k++) send_bits(w[k], 32);
        pulse_load();
        chk(cap_n == base + 4, "R4 R6 word count", cap_n - base, 4);
        if (cap_n >= base + 4) begin
            for (int k = 0; k < 4; k++) begin
                chk(cap_addr[base+k] == 8'h15, "R6 address held", cap_addr[base+k], 8'h15);
                chk(cap_idx[base+k] == 2'(k), "R6 sub-index", cap_idx[base+k], k);
                chk(cap_data[base+k] == w[k], "R4 bank data", cap_data[base+k], w[k]);
                chk(cap_cyc[base+k] == cap_cyc[base] + k, "R6 consecutive", cap_cyc[base+k] - cap_cyc[base], k);
            end
        end
    endtask

    task automatic t_range_edges();
        int base = cap_n;
        send_bits(32'h13, 8);
        send_bits(32'h123456, 24);
        pulse_load();
        check_ctrl_write(base, 8'h13, 24'h123456, "R3 below bank range");
        base = cap_n;
        send_bits(32'h17, 8);
        send_bits(32'h654321, 24);
        pulse_load();
        check_ctrl_write(base, 8'h17, 24'h654321, "R3 above bank range");
        base = cap_n;
        send_bits(32'h16, 8);
        for (int k = 0; k < 4; k++) send_bits(32'h1111_0000 + k, 32);
        pulse_load();
        chk(cap_n == base + 4, "R4 top of bank range", cap_n - base, 4);
        if (cap_n >= base + 4)
            chk(cap_data[base+3] == 32'h1111_0003, "R4 last bank word", cap_data[base+3], 32'h1111_0003);
    endtask

    task automatic t_early_load();
        int base = cap_n;
        send_bits(32'h02, 8);
        send_bits(32'h000ABC, 12);
        pulse_load();
        chk(cap_n == base, "R5 early strobe ignored", cap_n - base, 0);
        send_bits(32'h000DEF, 12);
        pulse_load();
        check_ctrl_write(base, 8'h02, 24'hDEFABC, "R5 transfer continues");
    endtask

    task automatic t_extra_bits();
        int base = cap_n;
        send_bits(32'h07, 8);
        send_bits(32'h0F0F0F, 24);
        send_bits(32'hFFFFFFFF, 5);
        pulse_load();
        check_ctrl_write(base, 8'h07, 24'h0F0F0F, "R7 extra bits ignored");
    endtask

    task automatic t_idle_load();
        int base = cap_n;
        pulse_load();
        chk(cap_n == base, "R9 idle strobe", cap_n - base, 0);
    endtask

    task automatic t_reset_mid();
        int base = cap_n;
        send_bits(32'h14, 8);
        send_bits(32'hCAFEBABE, 32);
        send_bits(32'h00000123, 9);
        @(negedge clk) rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(wr_en == 1'b0, "R1 reset mid transfer", wr_en, 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        send_bits(32'h03, 8);
        send_bits(32'h00BEEF, 24);
        pulse_load();
        check_ctrl_write(base, 8'h03, 24'h00BEEF, "R1 partial discarded");
    endtask

    task automatic t_back_to_back();
        int base = cap_n;
        send_bits(32'h0A, 8);
        send_bits(32'h111111, 24);
        repeat (4) @(negedge clk);
        sload = 1'b1;
        repeat (4) @(negedge clk);
        sload = 1'b0;
        send_bits(32'h0B, 8);
        send_bits(32'h222222, 24);
        pulse_load();
        chk(cap_n == base + 2, "R8 two transfers", cap_n - base, 2);
        if (cap_n >= base + 2) begin
            chk(cap_addr[base] == 8'h0A && cap_data[base] == 32'h111111, "R8 first", cap_data[base], 32'h111111);
            chk(cap_addr[base+1] == 8'h0B && cap_data[base+1] == 32'h222222, "R8 second", cap_data[base+1], 32'h222222);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_ctrl_word();
        t_bank_words();
        t_range_edges();
        t_early_load();
        t_extra_bits();
        t_idle_load();
        t_reset_mid();
        t_back_to_back();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        #1500000;
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule